// File: doc/BRIEF.md
# Serial Receive Path with Line-Status Flags

This block is the receive half of an asynchronous serial port. A 16x oversampling enable from an external rate generator paces the work. The block recovers characters of 5 to 8 data bits from a single serial input and checks an optional parity bit. It stores the characters in a receive queue that a host drains through a read-strobe port. The queue depth is a parameter, 16 by default, and must be a power of two.

Besides the data, the block reports line errors through sticky flags: bad parity, a bad stop bit, a held-low line, and a character lost to a full queue. Software clears each of these flags by writing one. Two more flags pace the host. One shows that the queue holds at least a programmed number of characters. The other shows that characters are waiting but the queue has been quiet for a programmed number of bit times. A synchronous receive-reset input discards the queue and any character in progress.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the queue is empty (count 0, empty 1, full 0) and every flag output is 0.
- R2: Characters are taken LSB first. The word length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, and unused upper bits of read data are 0. Characters are read back in arrival order, and the read data shows the oldest entry while rd_en pops it.
- R3: A low level on the line is only accepted as a start bit if it still reads low half a bit time later. A shorter low pulse produces no character.
- R4: With parity enabled and stick mode off, even-select 1 expects an even number of ones over data plus parity bit and even-select 0 expects an odd number. A mismatch sets the parity flag, and the character is still stored.
- R5: With stick mode on, the expected parity bit is 0 when even-select is 1 and 1 when even-select is 0, whatever the data.
- R6: A stop bit sampled as 0 sets the framing flag.
- R7: If every sample from the start bit through the stop bit reads 0, the break flag and the framing flag are both set and a single zero character is stored. Reception then waits for the line to return high.
- R8: The parity, framing, break and overflow flags stay set until the matching clear input is pulsed. The line-status output is the OR of the parity, framing and break flags.
- R9: The data-available flag is 1 exactly while the queue count is nonzero and at least the trigger level.
- R10: The time-out flag sets once the queue is non-empty and no push or pop has occurred for the compare number of bit times (16 enable pulses each). A pop clears it.
- R11: A character that arrives while the queue is full is dropped, the queue contents are unchanged, and the overflow flag is set.
- R12: The receive reset empties the queue and abandons a character being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_rst | input | 1 | Synchronous receive reset: queue and receiver state |
| os_tick | input | 1 | 16x oversampling enable |
| rx_in | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select |
| cfg_par_stick | input | 1 | Stick parity mode |
| cfg_trig | input | CNTW | Data-available trigger level |
| cfg_to_cmp | input | 8 | Idle time-out compare value in bit times |
| rd_en | input | 1 | Pop the oldest character |
| rd_data | output | 8 | Oldest character |
| fifo_count | output | CNTW | Characters held |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| clr_pe | input | 1 | Write-one clear of parity flag |
| clr_fe | input | 1 | Write-one clear of framing flag |
| clr_brk | input | 1 | Write-one clear of break flag |
| clr_ovf | input | 1 | Write-one clear of overflow flag |
| pe_flag | output | 1 | Parity error seen |
| fe_flag | output | 1 | Framing error seen |
| brk_flag | output | 1 | Break seen |
| ls_flag | output | 1 | Any line-status error |
| ovf_flag | output | 1 | Character lost to a full queue |
| avail_flag | output | 1 | Count at or above trigger |
| tmo_flag | output | 1 | Idle time-out |

## Verification
If the bit counter or the oversample phase drifts, the fault shows within one character. Either the data read back is shifted, or a false parity or framing flag appears on a clean frame. Errors in the queue pointers show at the next read as wrong order or a wrong count, and in the full and empty outputs after at most a queue's worth of characters. Errors in the idle timer move the time-out edge by whole bit times, which shows against the expected 16-cycle grid within a few cycles.

// File: rtl/rx_pkg.sv
// Shared types and helpers for the serial receive path.
// Assumes word length codes 0..3 map to 5..8 data bits.
package rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } rx_state_t;

    // Number of data bits for a word length code.
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // Expected parity bit for the given data and mode.
    function automatic logic parity_expect(input logic [7:0] d, input logic [1:0] code,
                                           input logic even, input logic stick);
        logic [7:0] m;
        m = 8'hFF >> (2'd3 - code);
        if (stick) return ~even;
        return even ? ^(d & m) : ~^(d & m);
    endfunction
endpackage

// File: rtl/rx_frame.sv
// Character recovery: synchronises the line, validates the start bit at
// mid-bit, samples data, parity and stop at their centres, and emits one
// push pulse per character with its error indications.
// Assumes OSR enable pulses per bit.
module rx_frame
    import rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       push,
    output logic [7:0] push_data,
    output logic       push_pe,
    output logic       push_fe,
    output logic       push_brk
);
    localparam int OSW = $clog2(OSR);
    localparam logic [OSW-1:0] MID  = OSW'(OSR / 2 - 1);
    localparam logic [OSW-1:0] LAST = OSW'(OSR - 1);

    rx_state_t      state;
    logic [OSW-1:0] os_cnt;
    logic [2:0]     bit_idx;
    logic [7:0]     data_r;
    logic           par_r;
    logic           zeros_r;
    logic           rx_q1, rx_q;
    logic [3:0]     last_idx;
    logic           par_exp;

    assign last_idx = word_bits(cfg_wlen) - 4'd1;
    assign par_exp  = parity_expect(data_r, cfg_wlen, par_even, par_stick);

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q1 <= 1'b1;
            rx_q  <= 1'b1;
        end else begin
            rx_q1 <= rx_in;
            rx_q  <= rx_q1;
        end
    end

    // Frame state machine and bit sampling.
    always_ff @(posedge clk) begin
        push <= 1'b0;
        if (!rst_n || clr) begin
            state     <= ST_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            data_r    <= '0;
            par_r     <= 1'b0;
            zeros_r   <= 1'b0;
            push_data <= '0;
            push_pe   <= 1'b0;
            push_fe   <= 1'b0;
            push_brk  <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_IDLE: if (!rx_q) begin
                    state  <= ST_START;
                    os_cnt <= '0;
                end
                ST_START: if (os_cnt == MID) begin
                    os_cnt  <= '0;
                    bit_idx <= '0;
                    data_r  <= '0;
                    zeros_r <= 1'b1;
                    state   <= rx_q ? ST_IDLE : ST_DATA;
                end else os_cnt <= os_cnt + 1'b1;
                ST_DATA: if (os_cnt == LAST) begin
                    os_cnt          <= '0;
                    data_r[bit_idx] <= rx_q;
                    zeros_r         <= zeros_r & ~rx_q;
                    if ({1'b0, bit_idx} == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                    else bit_idx <= bit_idx + 1'b1;
                end else os_cnt <= os_cnt + 1'b1;
                ST_PAR: if (os_cnt == LAST) begin
                    os_cnt  <= '0;
                    par_r   <= rx_q;
                    zeros_r <= zeros_r & ~rx_q;
                    state   <= ST_STOP;
                end else os_cnt <= os_cnt + 1'b1;
                ST_STOP: if (os_cnt == LAST) begin
                    os_cnt    <= '0;
                    push      <= 1'b1;
                    push_data <= data_r;
                    push_pe   <= par_en && (par_r != par_exp);
                    push_fe   <= ~rx_q;
                    push_brk  <= zeros_r & ~rx_q;
                    state     <= rx_q ? ST_IDLE : ST_HOLD;
                end else os_cnt <= os_cnt + 1'b1;
                ST_HOLD: if (rx_q) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: one character yields exactly one single-cycle push.
    p_push_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
    // R7: after a low stop bit the receiver never re-arms while the line is low.
    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_HOLD && !rx_q) |=> state == ST_HOLD);
endmodule

// File: rtl/rx_fifo.sv
// Character queue with extra-bit pointers; count, empty and full are derived
// from the pointers. Read data shows the oldest entry. Assumes DEPTH is a
// power of two. A push while full is dropped and reported on ovf_evt.
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full,
    output logic                       ovf_evt
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;
    logic         do_push, do_pop;

    assign count   = wr_ptr - rd_ptr;
    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf_evt = push && full;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R11: the pointers never drift more than DEPTH apart.
    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/rx_idle_timer.sv
// Idle time-out: counts bit times since the last queue push or pop and sets
// a flag when the queue holds data and the count equals the compare value.
// Assumes OSR enable pulses per bit time; the count saturates.
module rx_idle_timer #(
    parameter int OSR = 16,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          activity,
    input  logic          pop,
    input  logic          nonempty,
    input  logic [CW-1:0] cmp,
    output logic          tmo
);
    localparam int OSW = $clog2(OSR);
    localparam logic [OSW-1:0] LAST = OSW'(OSR - 1);

    logic [OSW-1:0] pre;
    logic [CW-1:0]  idle;

    // Bit-time prescaler and saturating idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || activity) begin
            pre  <= '0;
            idle <= '0;
        end else if (tick) begin
            pre <= pre + 1'b1;
            if (pre == LAST && idle != '1) idle <= idle + 1'b1;
        end
    end

    // Time-out flag: set on compare match with data waiting, cleared by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || pop) tmo <= 1'b0;
        else if (nonempty && idle == cmp) tmo <= 1'b1;
    end
endmodule

// File: rtl/serial_rx_status.sv
// Top of the serial receive path: frame recovery, character queue, idle
// timer, and the sticky write-one-to-clear line-status flags. Assumes
// os_tick pulses 16 times per bit and DEPTH is a power of two.
module serial_rx_status #(
    parameter int DEPTH = 16,
    parameter int OSR   = 16,
    parameter int CNTW  = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_rst,
    input  logic            os_tick,
    input  logic            rx_in,
    input  logic [1:0]      cfg_wlen,
    input  logic            cfg_par_en,
    input  logic            cfg_par_even,
    input  logic            cfg_par_stick,
    input  logic [CNTW-1:0] cfg_trig,
    input  logic [7:0]      cfg_to_cmp,
    input  logic            rd_en,
    output logic [7:0]      rd_data,
    output logic [CNTW-1:0] fifo_count,
    output logic            fifo_empty,
    output logic            fifo_full,
    input  logic            clr_pe,
    input  logic            clr_fe,
    input  logic            clr_brk,
    input  logic            clr_ovf,
    output logic            pe_flag,
    output logic            fe_flag,
    output logic            brk_flag,
    output logic            ls_flag,
    output logic            ovf_flag,
    output logic            avail_flag,
    output logic            tmo_flag
);
    logic       frm_push, frm_pe, frm_fe, frm_brk, ovf_evt, pop;
    logic [7:0] frm_data;

    assign pop = rd_en && !fifo_empty;

    rx_frame #(.OSR(OSR)) i_frame (
        .clk(clk), .rst_n(rst_n), .clr(rx_rst), .tick(os_tick), .rx_in(rx_in),
        .cfg_wlen(cfg_wlen), .par_en(cfg_par_en), .par_even(cfg_par_even),
        .par_stick(cfg_par_stick), .push(frm_push), .push_data(frm_data),
        .push_pe(frm_pe), .push_fe(frm_fe), .push_brk(frm_brk)
    );

    rx_fifo #(.DEPTH(DEPTH), .W(8)) i_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_rst), .push(frm_push),
        .push_data(frm_data), .pop(rd_en), .rd_data(rd_data),
        .count(fifo_count), .empty(fifo_empty), .full(fifo_full), .ovf_evt(ovf_evt)
    );

    rx_idle_timer #(.OSR(OSR), .CW(8)) i_timer (
        .clk(clk), .rst_n(rst_n), .clr(rx_rst), .tick(os_tick),
        .activity(frm_push || pop), .pop(pop), .nonempty(!fifo_empty),
        .cmp(cfg_to_cmp), .tmo(tmo_flag)
    );

    // Sticky error flags; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_flag  <= 1'b0;
            fe_flag  <= 1'b0;
            brk_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (frm_push && frm_pe)       pe_flag  <= 1'b1;
            else if (clr_pe)              pe_flag  <= 1'b0;
            if (frm_push && frm_fe)       fe_flag  <= 1'b1;
            else if (clr_fe)              fe_flag  <= 1'b0;
            if (frm_push && frm_brk)      brk_flag <= 1'b1;
            else if (clr_brk)             brk_flag <= 1'b0;
            if (ovf_evt)                  ovf_flag <= 1'b1;
            else if (clr_ovf)             ovf_flag <= 1'b0;
        end
    end

    assign ls_flag    = pe_flag | fe_flag | brk_flag;
    assign avail_flag = !fifo_empty && (fifo_count >= cfg_trig);

    // R2: an accepted character grows the queue by one.
    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n || rx_rst)
        (frm_push && !fifo_full && !rd_en) |=> fifo_count == $past(fifo_count) + 1'b1);
    // R11: a character arriving at a full queue leaves it full.
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n || rx_rst)
        (frm_push && fifo_full && !rd_en) |=> fifo_full);
    // R8: parity flag holds until cleared.
    p_sticky_pe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_flag && !clr_pe) |=> pe_flag);
    // R10: the time-out flag only rises with data waiting.
    p_tmo_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> !fifo_empty);
    // R12: receive reset empties the queue.
    p_rst_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> fifo_empty);
endmodule

// File: tb/test_serial_rx_status.sv
`timescale 1ns/1ps
module test_serial_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, rx_rst = 1'b0, os_tick = 1'b1, rx_in = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
    logic [4:0] cfg_trig = 5'd1;
    logic [7:0] cfg_to_cmp = 8'd255;
    logic       rd_en = 1'b0, clr_pe = 1'b0, clr_fe = 1'b0, clr_brk = 1'b0, clr_ovf = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fifo_count;
    logic       fifo_empty, fifo_full, pe_flag, fe_flag, brk_flag, ls_flag;
    logic       ovf_flag, avail_flag, tmo_flag;
    int checks = 0, failures = 0, cyc = 0, push_cyc = 0;
    logic [4:0] prev_cnt = 5'd0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_rx_status i_serial_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .cfg_trig(cfg_trig), .cfg_to_cmp(cfg_to_cmp),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .clr_pe(clr_pe),
        .clr_fe(clr_fe), .clr_brk(clr_brk), .clr_ovf(clr_ovf), .pe_flag(pe_flag),
        .fe_flag(fe_flag), .brk_flag(brk_flag), .ls_flag(ls_flag),
        .ovf_flag(ovf_flag), .avail_flag(avail_flag), .tmo_flag(tmo_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;
    // Record the cycle at which the queue count last grew.
    always @(negedge clk) begin
        if (fifo_count > prev_cnt) push_cyc = cyc;
        prev_cnt = fifo_count;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic clear_all;
        @(negedge clk); clr_pe = 1; clr_fe = 1; clr_brk = 1; clr_ovf = 1;
        @(negedge clk); clr_pe = 0; clr_fe = 0; clr_brk = 0; clr_ovf = 0;
    endtask

    // Parity bit the sender puts on the line for the current configuration.
    function automatic logic good_parity(input logic [7:0] d);
        logic [7:0] m = 8'hFF >> (3 - cfg_wlen);
        int ones = 0;
        for (int i = 0; i < 8; i++) if (m[i] && d[i]) ones++;
        if (cfg_par_stick) return !cfg_par_even;
        return cfg_par_even ? logic'(ones % 2) : logic'(1 - ones % 2);
    endfunction

    task automatic send(input logic [7:0] d, input bit flip, input logic stop_v);
        int nb = 5 + cfg_wlen;
        @(negedge clk); rx_in = 1'b0; idle(16);
        for (int i = 0; i < nb; i++) begin rx_in = d[i]; idle(16); end
        if (cfg_par_en) begin rx_in = good_parity(d) ^ flip; idle(16); end
        rx_in = stop_v; idle(16);
        rx_in = 1'b1; idle(3);
    endtask

    initial begin
        logic [7:0] exp_d;
        idle(3); rst_n = 1'b1; idle(2);
        // R1: reset state
        check(fifo_empty && fifo_count == 0 && !fifo_full, "R1 queue", fifo_count, 0);
        check({pe_flag, fe_flag, brk_flag, ls_flag, ovf_flag, avail_flag, tmo_flag} == 0,
              "R1 flags", {pe_flag, fe_flag, brk_flag, ls_flag, ovf_flag, avail_flag, tmo_flag}, 0);

        // R2 R4 R5: sweep word lengths, parity modes and data, with bad parity injected
        for (int wl = 0; wl < 4; wl++) begin
            for (int mode = 0; mode < 5; mode++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] d = 8'hA5 ^ 8'(k * 77 + mode * 19 + wl * 5);
                    bit flip = (k == 2) && (mode != 0);
                    cfg_wlen = 2'(wl);
                    cfg_par_en = (mode != 0);
                    cfg_par_even = (mode == 1) || (mode == 3);
                    cfg_par_stick = (mode >= 3);
                    send(d, flip, 1'b1);
                    exp_d = d & (8'hFF >> (3 - wl));
                    check(fifo_count == 1, "R2 count", fifo_count, 1);
                    check(rd_data == exp_d, mode >= 3 ? "R5 data" : "R2 data", rd_data, exp_d);
                    check(pe_flag == flip, mode >= 3 ? "R5 parity" : "R4 parity", pe_flag, flip);
                    pop(); clear_all();
                end
            end
        end
        cfg_wlen = 2'd3; cfg_par_en = 0; cfg_par_stick = 0;

        // R3: short low glitch is not a start bit
        @(negedge clk); rx_in = 0; idle(5); rx_in = 1; idle(200);
        check(fifo_empty, "R3 glitch ignored", fifo_count, 0);

        // R6: framing error
        send(8'h5A, 0, 1'b0);
        check(fe_flag && !brk_flag, "R6 framing", {fe_flag, brk_flag}, 2'b10);
        check(rd_data == 8'h5A, "R6 data kept", rd_data, 8'h5A);
        pop();

        // R8: sticky until cleared, even across a clean frame
        send(8'h33, 0, 1'b1);
        check(fe_flag && ls_flag, "R8 sticky fe", {fe_flag, ls_flag}, 2'b11);
        pop();
        @(negedge clk); clr_fe = 1; @(negedge clk); clr_fe = 0;
        check(!fe_flag && !ls_flag, "R8 cleared", {fe_flag, ls_flag}, 0);

        // R7: break (line low for 12 bit times)
        @(negedge clk); rx_in = 0; idle(16 * 12); rx_in = 1; idle(40);
        check(fifo_count == 1, "R7 one char", fifo_count, 1);
        check(rd_data == 8'h00, "R7 zero char", rd_data, 0);
        check(brk_flag && fe_flag && ls_flag, "R7 flags", {brk_flag, fe_flag, ls_flag}, 3'b111);
        pop();
        @(negedge clk); clr_brk = 1; @(negedge clk); clr_brk = 0;
        check(!brk_flag && fe_flag && ls_flag, "R8 brk cleared alone", {brk_flag, fe_flag}, 2'b01);
        clear_all();
        check(!ls_flag, "R8 ls low", ls_flag, 0);

        // R9: data-available threshold
        cfg_trig = 5'd4;
        for (int i = 0; i < 3; i++) send(8'(i + 1), 0, 1'b1);
        check(!avail_flag, "R9 below trigger", avail_flag, 0);
        send(8'h04, 0, 1'b1);
        check(avail_flag, "R9 at trigger", avail_flag, 1);
        pop(); idle(1);
        check(!avail_flag, "R9 drops below", avail_flag, 0);
        for (int i = 0; i < 3; i++) begin
            exp_d = 8'(i + 2);
            check(rd_data == exp_d, "R2 order", rd_data, exp_d);
            pop();
        end
        cfg_trig = 5'd1;

        // R10: idle time-out after 3 bit times
        cfg_to_cmp = 8'd3;
        send(8'hC3, 0, 1'b1);
        while (cyc < push_cyc + 47) @(negedge clk);
        check(!tmo_flag, "R10 early", tmo_flag, 0);
        while (cyc < push_cyc + 51) @(negedge clk);
        check(tmo_flag, "R10 fires", tmo_flag, 1);
        pop(); idle(1);
        check(!tmo_flag, "R10 cleared by read", tmo_flag, 0);
        idle(100);
        check(!tmo_flag, "R10 empty stays low", tmo_flag, 0);
        cfg_to_cmp = 8'd255;

        // R11: overflow
        for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 0, 1'b1);
        check(fifo_full && fifo_count == 16, "R11 full", fifo_count, 16);
        check(ovf_flag, "R11 overflow flag", ovf_flag, 1);
        for (int i = 0; i < 16; i++) begin
            exp_d = 8'(8'h40 + i);
            check(rd_data == exp_d, "R11 contents", rd_data, exp_d);
            pop();
        end
        check(fifo_empty, "R11 drained", fifo_count, 0);
        @(negedge clk); clr_ovf = 1; @(negedge clk); clr_ovf = 0;
        check(!ovf_flag, "R8 ovf cleared", ovf_flag, 0);

        // R12: receive reset empties queue and aborts a character
        send(8'h11, 0, 1'b1); send(8'h22, 0, 1'b1);
        @(negedge clk); rx_rst = 1; @(negedge clk); rx_rst = 0;
        check(fifo_empty && fifo_count == 0, "R12 queue emptied", fifo_count, 0);
        @(negedge clk); rx_in = 0; idle(16); rx_in = 1; idle(30);
        @(negedge clk); rx_rst = 1; @(negedge clk); rx_rst = 0;
        idle(250);
        check(fifo_empty, "R12 char aborted", fifo_count, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule